// File: doc/BRIEF.md
# DMA Channel Address and Count Engine

This block is the address and transfer-count datapath of a single DMA channel. It keeps two 24-bit address pointers, one per side of the transfer (side A and side B), and a 16-bit count of the transfers left in the current block. Each pointer has a start-address register, and the count has a reload register. A small register port lets software set up the pointers, the count and a per-channel control word. A one-cycle `xfer_done` strobe, raised by the data mover after each completed transfer, moves the pointers and decrements the count.

The control word sets which side is the source, whether a transfer is one or two bytes wide, whether each pointer moves and by how much, whether side B is used at all (flyby operation), and whether a new block starts automatically when the count runs out. When the last transfer of a block completes, a sticky terminal-count flag is set. Software clears it by writing a one. Bus arbitration, the data movement itself and the priority between channels belong to other blocks.

Top module: `dma_addr_engine`

## Requirements
- R1: Reads of the four address registers (offsets 00h, 04h, 08h, 0Ch) return zero in bits 31:24. Write data in bits 31:24 is discarded; only bits 23:0 are stored.
- R2: On each `xfer_done`, the side-A counter increases by the step that control bits 5:4 select (codes 0,1,2,3 give 0,1,2,4 bytes), but only when control bit 2 is set. Otherwise it holds.
- R3: On each `xfer_done`, the side-B counter increases by the step that control bits 7:6 select (same encoding), but only when control bit 3 is set.
- R4: While control bit 8 (flyby) is set, the side-B counter and the side-B start register keep their values. Transfers, reloads and writes to offsets 08h and 0Ch do not change them.
- R5: When control bit 0 is 0, `src_addr` shows the side-A counter and `dst_addr` shows the side-B counter. When it is 1, the two are swapped.
- R6: The block counter decrements by one on each `xfer_done`.
- R7: `xfer_wide` follows control bit 1 (0 = one byte, 1 = two bytes per transfer).
- R8: A block count of 0000h counts as 65535 transfers. A transfer from 0000h leaves FFFEh, and the 65535th transfer is the terminal one.
- R9: Register offsets are: 00h A counter, 04h A start, 08h B counter, 0Ch B start, 10h block counter, 14h block reload, 1Ch control (bits 9:0), 1Eh status (bit 0). All registers reset to zero.
- R10: A transfer that finds the block counter at 1 sets status bit 0. The bit stays set until a write to 1Eh with bit 0 high. If a set and a clear happen in the same cycle, the set wins. The bit is visible on `tc_flag`.
- R11: With control bit 9 set, the terminal transfer loads both address counters from their start registers and the block counter from the reload register. Without it, the counters step as usual.
- R12: A register write to a counter in the same cycle as `xfer_done` takes priority over the step or decrement.
- R13: Address arithmetic wraps modulo 2^24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| xfer_done | input | 1 | One-cycle strobe per completed transfer |
| src_addr | output | 24 | Current source address |
| dst_addr | output | 24 | Current destination address |
| blk_count | output | 16 | Transfers left in the block |
| xfer_wide | output | 1 | Two-byte transfer selected |
| tc_flag | output | 1 | Sticky terminal-count status |

## Verification
On every cycle, the assertions check the following: side B stays frozen in flyby mode, a register write beats a same-cycle step, an idle pointer holds, a count of zero steps to FFFEh, the terminal transfer sets the flag, the flag stays set until cleared, and the upper address bits read as zero. The bench scenarios are needed for the rest: the step-size encoding, source/destination swapping, 24-bit wraparound, reloading for a new block, a set beating a clear of the flag, and the full 65535-transfer block that starts from a zero count. The bench's reference model also follows every output on every cycle.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;

    typedef struct packed {
        logic       reload;
        logic       flyby;
        logic [1:0] b_step;
        logic [1:0] a_step;
        logic       b_move;
        logic       a_move;
        logic       wide;
        logic       dir;
    } dma_ctrl_t;

    localparam int CTRL_W = $bits(dma_ctrl_t);

    localparam logic [4:0] OFF_A_CNT  = 5'h00;
    localparam logic [4:0] OFF_A_BASE = 5'h04;
    localparam logic [4:0] OFF_B_CNT  = 5'h08;
    localparam logic [4:0] OFF_B_BASE = 5'h0C;
    localparam logic [4:0] OFF_LEN    = 5'h10;
    localparam logic [4:0] OFF_RELOAD = 5'h14;
    localparam logic [4:0] OFF_CTRL   = 5'h1C;
    localparam logic [4:0] OFF_STAT   = 5'h1E;

    function automatic logic [2:0] step_bytes(input logic [1:0] code);
        case (code)
            2'd0:    step_bytes = 3'd0;
            2'd1:    step_bytes = 3'd1;
            2'd2:    step_bytes = 3'd2;
            default: step_bytes = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/dma_ptr.sv
module dma_ptr
    import dma_eng_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          freeze,
    input  logic          cnt_we,
    input  logic          base_we,
    input  logic [AW-1:0] wdata,
    input  logic          adv,
    input  logic          move_en,
    input  logic [1:0]    step_code,
    input  logic          reload,
    output logic [AW-1:0] cnt,
    output logic [AW-1:0] base
);

    typedef struct packed {
        logic [AW-1:0] cnt;
        logic [AW-1:0] base;
    } ptr_st_t;

    ptr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!freeze) begin
            if (base_we)
                st_d.base = wdata;
            if (cnt_we)
                st_d.cnt = wdata;
            else if (reload)
                st_d.cnt = st_q.base;
            else if (adv && move_en)
                st_d.cnt = st_q.cnt + AW'(step_bytes(step_code));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt  = st_q.cnt;
    assign base = st_q.base;

    assert_flyby_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> ($stable(cnt) && $stable(base)));

    assert_write_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!freeze && cnt_we) |=> (cnt == $past(wdata)));

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_we && !reload && !(adv && move_en)) |=> $stable(cnt));

endmodule

// File: rtl/dma_len.sv
module dma_len #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cnt_we,
    input  logic          len_we,
    input  logic [CW-1:0] wdata,
    input  logic          adv,
    input  logic          reload_en,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] len,
    output logic          term
);

    localparam logic [CW-1:0] ONE      = CW'(1);
    localparam logic [CW-1:0] FROM_ZERO = {CW{1'b1}} - ONE;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] len;
    } len_st_t;

    len_st_t st_d, st_q;

    assign term = adv && (st_q.cnt == ONE);

    always_comb begin
        st_d = st_q;
        if (len_we)
            st_d.len = wdata;
        if (cnt_we)
            st_d.cnt = wdata;
        else if (term && reload_en)
            st_d.cnt = st_q.len;
        else if (adv)
            st_d.cnt = (st_q.cnt == '0) ? FROM_ZERO : st_q.cnt - ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
    assign len = st_q.len;

    assert_zero_is_max_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !cnt_we && cnt == '0) |=> (cnt == FROM_ZERO));

    assert_count_write_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we |=> (cnt == $past(wdata)));

endmodule

// File: rtl/dma_addr_engine.sv
module dma_addr_engine
    import dma_eng_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 16,
    parameter int REG_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [4:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              xfer_done,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr,
    output logic [CNT_W-1:0]  blk_count,
    output logic              xfer_wide,
    output logic              tc_flag
);

    typedef struct packed {
        dma_ctrl_t ctrl;
        logic      tc;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [ADDR_W-1:0] a_cnt, a_base, b_cnt, b_base;
    logic [CNT_W-1:0]  len_cnt, len_rel;
    logic              term;
    logic              unused_hi;

    assign unused_hi = ^reg_wdata[REG_W-1:ADDR_W];

    logic wr_a_cnt, wr_a_base, wr_b_cnt, wr_b_base, wr_len, wr_rel, wr_ctrl, wr_stat;
    assign wr_a_cnt  = reg_wr && (reg_addr == OFF_A_CNT);
    assign wr_a_base = reg_wr && (reg_addr == OFF_A_BASE);
    assign wr_b_cnt  = reg_wr && (reg_addr == OFF_B_CNT);
    assign wr_b_base = reg_wr && (reg_addr == OFF_B_BASE);
    assign wr_len    = reg_wr && (reg_addr == OFF_LEN);
    assign wr_rel    = reg_wr && (reg_addr == OFF_RELOAD);
    assign wr_ctrl   = reg_wr && (reg_addr == OFF_CTRL);
    assign wr_stat   = reg_wr && (reg_addr == OFF_STAT);

    logic do_reload;
    assign do_reload = term && st_q.ctrl.reload;

    dma_ptr #(.AW(ADDR_W)) u_ptr_a (
        .clk(clk), .rst_n(rst_n), .freeze(1'b0),
        .cnt_we(wr_a_cnt), .base_we(wr_a_base), .wdata(reg_wdata[ADDR_W-1:0]),
        .adv(xfer_done), .move_en(st_q.ctrl.a_move), .step_code(st_q.ctrl.a_step),
        .reload(do_reload), .cnt(a_cnt), .base(a_base)
    );

    dma_ptr #(.AW(ADDR_W)) u_ptr_b (
        .clk(clk), .rst_n(rst_n), .freeze(st_q.ctrl.flyby),
        .cnt_we(wr_b_cnt), .base_we(wr_b_base), .wdata(reg_wdata[ADDR_W-1:0]),
        .adv(xfer_done), .move_en(st_q.ctrl.b_move), .step_code(st_q.ctrl.b_step),
        .reload(do_reload), .cnt(b_cnt), .base(b_base)
    );

    dma_len #(.CW(CNT_W)) u_len (
        .clk(clk), .rst_n(rst_n),
        .cnt_we(wr_len), .len_we(wr_rel), .wdata(reg_wdata[CNT_W-1:0]),
        .adv(xfer_done), .reload_en(st_q.ctrl.reload),
        .cnt(len_cnt), .len(len_rel), .term(term)
    );

    always_comb begin
        st_d = st_q;
        if (wr_ctrl)
            st_d.ctrl = dma_ctrl_t'(reg_wdata[CTRL_W-1:0]);
        if (term)
            st_d.tc = 1'b1;
        else if (wr_stat && reg_wdata[0])
            st_d.tc = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFF_A_CNT:  reg_rdata = REG_W'(a_cnt);
            OFF_A_BASE: reg_rdata = REG_W'(a_base);
            OFF_B_CNT:  reg_rdata = REG_W'(b_cnt);
            OFF_B_BASE: reg_rdata = REG_W'(b_base);
            OFF_LEN:    reg_rdata = REG_W'(len_cnt);
            OFF_RELOAD: reg_rdata = REG_W'(len_rel);
            OFF_CTRL:   reg_rdata = REG_W'(st_q.ctrl);
            OFF_STAT:   reg_rdata = REG_W'(st_q.tc);
            default:    reg_rdata = '0;
        endcase
    end

    assign src_addr  = st_q.ctrl.dir ? b_cnt : a_cnt;
    assign dst_addr  = st_q.ctrl.dir ? a_cnt : b_cnt;
    assign blk_count = len_cnt;
    assign xfer_wide = st_q.ctrl.wide;
    assign tc_flag   = st_q.tc;

    assert_addr_hi_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFF_A_CNT || reg_addr == OFF_A_BASE ||
         reg_addr == OFF_B_CNT || reg_addr == OFF_B_BASE)
        |-> (reg_rdata[REG_W-1:ADDR_W] == '0));

    assert_term_sets_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && blk_count == CNT_W'(1)) |=> tc_flag);

    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_flag && !(reg_wr && reg_addr == OFF_STAT)) |=> tc_flag);

endmodule

// File: tb/test_dma_addr_engine.sv
module test_dma_addr_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        xfer_done = 1'b0;
    logic [23:0] src_addr, dst_addr;
    logic [15:0] blk_count;
    logic        xfer_wide, tc_flag;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    dma_addr_engine i_dma_addr_engine (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_done(xfer_done),
        .src_addr(src_addr), .dst_addr(dst_addr), .blk_count(blk_count),
        .xfer_wide(xfer_wide), .tc_flag(tc_flag)
    );

    // Behavioural reference model
    logic [31:0] ma, msa, mb, msb, mc, ml, mctl;
    logic        mtc;
    logic [31:0] na, nsa, nb, nsb, nc, nl, nctl, eff;
    logic        ntc, term, fly;

    function automatic logic [31:0] stepv(input logic [1:0] c);
        return (c == 2'd3) ? 32'd4 : {30'd0, c};
    endfunction

    function automatic logic [31:0] model_read(input logic [4:0] a);
        case (a)
            5'h00: return ma;
            5'h04: return msa;
            5'h08: return mb;
            5'h0C: return msb;
            5'h10: return mc;
            5'h14: return ml;
            5'h1C: return mctl;
            5'h1E: return {31'd0, mtc};
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            ma = 0; msa = 0; mb = 0; msb = 0; mc = 0; ml = 0; mctl = 0; mtc = 0;
        end else begin
            na = ma; nsa = msa; nb = mb; nsb = msb; nc = mc; nl = ml; nctl = mctl; ntc = mtc;
            fly  = mctl[8];
            eff  = (mc == 0) ? 32'd65535 : mc;
            term = xfer_done && (eff == 1);
            if (xfer_done) begin
                if (term && mctl[9]) begin
                    na = msa;
                    if (!fly) nb = msb;
                    nc = ml;
                end else begin
                    if (mctl[2]) na = (ma + stepv(mctl[5:4])) & 32'hFFFFFF;
                    if (mctl[3] && !fly) nb = (mb + stepv(mctl[7:6])) & 32'hFFFFFF;
                    nc = eff - 1;
                end
                if (term) ntc = 1;
            end
            if (reg_wr) begin
                case (reg_addr)
                    5'h00: na = reg_wdata & 32'hFFFFFF;
                    5'h04: nsa = reg_wdata & 32'hFFFFFF;
                    5'h08: if (!fly) nb = reg_wdata & 32'hFFFFFF;
                    5'h0C: if (!fly) nsb = reg_wdata & 32'hFFFFFF;
                    5'h10: nc = reg_wdata & 32'hFFFF;
                    5'h14: nl = reg_wdata & 32'hFFFF;
                    5'h1C: nctl = reg_wdata & 32'h3FF;
                    5'h1E: if (reg_wdata[0] && !term) ntc = 0;
                    default: ;
                endcase
            end
            ma = na; msa = nsa; mb = nb; msb = nsb; mc = nc; ml = nl; mctl = nctl; mtc = ntc;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(src_addr == (mctl[0] ? mb[23:0] : ma[23:0]), "R5 src model", {8'd0, src_addr}, mctl[0] ? mb : ma);
            chk(dst_addr == (mctl[0] ? ma[23:0] : mb[23:0]), "R5 dst model", {8'd0, dst_addr}, mctl[0] ? ma : mb);
            chk(blk_count == mc[15:0], "R6 count model", {16'd0, blk_count}, mc);
            chk(tc_flag == mtc, "R10 flag model", {31'd0, tc_flag}, {31'd0, mtc});
            chk(xfer_wide == mctl[1], "R7 size model", {31'd0, xfer_wide}, {31'd0, mctl[1]});
            chk(reg_rdata == model_read(reg_addr), "R9 read model", reg_rdata, model_read(reg_addr));
        end
    end

    task automatic cyc(input bit w, input logic [4:0] a, input logic [31:0] d, input bit x);
        @(posedge clk); #2;
        reg_wr = w; reg_addr = a; reg_wdata = d; xfer_done = x;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        cyc(1, a, d, 0);
    endtask

    task automatic idle();
        cyc(0, 5'h00, 0, 0);
        #3;
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
        cyc(0, a, 0, 0);
        #3;
        chk(reg_rdata == exp, tag, reg_rdata, exp);
    endtask

    initial begin
        #(20 * 190000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        idle();
        chk(blk_count == 0 && tc_flag == 0 && src_addr == 0, "R9 reset state", {16'd0, blk_count}, 0);

        wr(5'h04, 32'h12345678);
        rd(5'h04, 32'h00345678, "R1 upper bits dropped");
        rd(5'h00, 32'h0, "R1 counter untouched by start write");

        wr(5'h1C, 32'h7C); wr(5'h00, 32'h100); wr(5'h08, 32'h200); wr(5'h10, 3);
        cyc(0, 0, 0, 1); cyc(0, 0, 0, 1); cyc(0, 0, 0, 1);
        idle();
        chk(src_addr == 24'h10C, "R2 A step of 4", {8'd0, src_addr}, 32'h10C);
        chk(dst_addr == 24'h203, "R3 B step of 1", {8'd0, dst_addr}, 32'h203);
        chk(blk_count == 0, "R6 count to zero", {16'd0, blk_count}, 0);
        chk(tc_flag == 1, "R10 terminal sets flag", {31'd0, tc_flag}, 1);

        wr(5'h1C, 32'h7D); idle();
        chk(src_addr == 24'h203 && dst_addr == 24'h10C, "R5 direction swap", {8'd0, src_addr}, 32'h203);

        wr(5'h1E, 1); idle();
        chk(tc_flag == 0, "R10 clear by write", {31'd0, tc_flag}, 0);

        wr(5'h1C, 32'h7F); idle();
        chk(xfer_wide == 1, "R7 wide select", {31'd0, xfer_wide}, 1);

        wr(5'h00, 32'hFFFFFE); wr(5'h10, 5);
        cyc(0, 0, 0, 1); idle();
        rd(5'h00, 32'h2, "R13 wrap modulo 2^24");
        chk(blk_count == 4, "R6 decrement", {16'd0, blk_count}, 4);

        wr(5'h1C, 32'h78); wr(5'h00, 32'h500);
        cyc(0, 0, 0, 1); idle();
        rd(5'h00, 32'h500, "R2 disabled pointer holds");
        chk(xfer_wide == 0, "R7 narrow select", {31'd0, xfer_wide}, 0);

        wr(5'h08, 32'h777);
        wr(5'h1C, 32'h178); wr(5'h08, 32'h555); wr(5'h0C, 32'h999);
        cyc(0, 0, 0, 1); idle();
        rd(5'h08, 32'h777, "R4 flyby B counter frozen");
        rd(5'h0C, 32'h0, "R4 flyby B start frozen");

        wr(5'h1C, 32'h7C);
        cyc(1, 5'h00, 32'h40, 1); idle();
        rd(5'h00, 32'h40, "R12 address write wins");
        cyc(1, 5'h10, 32'h9, 1); idle();
        chk(blk_count == 9, "R12 count write wins", {16'd0, blk_count}, 9);

        wr(5'h1E, 1); wr(5'h1C, 32'h27C); wr(5'h04, 32'h1000); wr(5'h0C, 32'h2000);
        wr(5'h14, 2); wr(5'h10, 1);
        cyc(0, 0, 0, 1); idle();
        chk(src_addr == 24'h1000, "R11 reload A", {8'd0, src_addr}, 32'h1000);
        chk(dst_addr == 24'h2000, "R11 reload B", {8'd0, dst_addr}, 32'h2000);
        chk(blk_count == 2, "R11 reload count", {16'd0, blk_count}, 2);
        chk(tc_flag == 1, "R11 flag on reload", {31'd0, tc_flag}, 1);
        rd(5'h14, 32'h2, "R9 reload register read");
        rd(5'h1C, 32'h27C, "R9 control register read");

        wr(5'h1E, 1); wr(5'h1C, 0); wr(5'h10, 0);
        cyc(0, 0, 0, 1); idle();
        chk(blk_count == 16'hFFFE, "R8 zero steps to FFFE", {16'd0, blk_count}, 32'hFFFE);
        for (int i = 0; i < 65533; i++) cyc(0, 0, 0, 1);
        idle();
        chk(blk_count == 1 && tc_flag == 0, "R8 one left, no flag", {16'd0, blk_count}, 1);
        cyc(0, 0, 0, 1); idle();
        chk(tc_flag == 1 && blk_count == 0, "R8 terminal on transfer 65535", {31'd0, tc_flag}, 1);

        wr(5'h1E, 1); wr(5'h10, 1);
        cyc(1, 5'h1E, 32'h1, 1); idle();
        chk(tc_flag == 1, "R10 set beats clear", {31'd0, tc_flag}, 1);

        idle();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule